// File: doc/BRIEF.md
# Double-Banked Configuration Register Unit

This block holds the configuration state that steers a compute engine's datapath units. It has two kinds of storage. The first is a shared array of 32-bit configuration words kept in two banks. The second is a small per-thread table of 16-bit thread settings for each of the issuing threads. Each thread selects which shared bank it works on through bit 0 of one of its own thread-setting entries. This lets software fill one bank while hardware runs from the other.

Each thread presents one 32-bit instruction word on a valid/ready channel. A thread-setting write completes in the cycle it is presented, and every thread can do one in the same cycle. The other instructions all share a single two-stage pipe:

- a copy of one or four general registers into shared words;
- a read of a shared word back into a general register;
- a masked read-modify-write of one byte lane.

The pipe accepts at most one of these per cycle, and a round-robin arbiter picks which thread goes next. A thread that is not picked sees ready low and must hold its word stable until ready is high. The general register file is outside the block. The block reads it through a combinational 128-bit group read port and writes it through a single write port. A per-thread pending flag tells stall logic when a read result has not yet landed.

Top module: `cfg_bank_unit`

## Requirements
- R1: A thread-setting write (opcode 0xB2, entry index in [23:16], value in [15:0]) is accepted in the same cycle by every thread that presents one. It updates only that thread's entry, and the new value appears on `tcfg_flat` after the next clock edge. Entry e of thread t sits at bits [(t*TCFG_N+e)*16 +: 16]. An index at or above TCFG_N has no effect.
- R2: A 32-bit register-to-config write (opcode 0xB0, bit 15 = 0, register index [21:16], config index [10:0]) stores that register's value in the issuing thread's active bank. The new value is visible to any later shared operation.
- R3: A 128-bit register-to-config write (opcode 0xB0, bit 15 = 1) rounds both the register index and the config index down to a multiple of 4. It then copies register k of the group to word k of the group, for k = 0 to 3.
- R4: A config read (opcode 0xB1, register index in the low 6 bits of [23:16], config index in the low 11 bits of [15:0]) drives `gpr_wr_en` for one cycle, starting one cycle after the acceptance edge, so the register is written two edges after acceptance. `rd_pending` for that thread is high from acceptance until that write. An index at or above CFG_N reads as zero.
- R5: The bank used by a shared operation is bit 0 of entry BSEL_IDX of the issuing thread, sampled when the operation is accepted.
- R6: Any write to a config index at or above `glob_base` goes to both banks in the same cycle.
- R7: A byte update uses opcodes 0xB3 to 0xB6, which select byte lane 0 to 3. The mask is in [23:16], the data in [15:8] and the config index in [7:0]. Lane bits become (data & mask) | (old & ~mask), and the other lanes are unchanged.
- R8: A register-to-config write that touches index RST_IDX zeroes every word below `glob_base` in the active bank, and then stores its own words. The other bank is untouched. A byte update to RST_IDX causes no clear.
- R9: At most one shared operation is accepted per cycle, and back-to-back operations are accepted on consecutive cycles. Competing threads are served round-robin, starting after the last thread served (thread 0 first after reset). No accepted operation is lost.
- R10: After reset, all words and thread entries are zero, `pipe_busy` and `rd_pending` are low, and no register write is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_base | input | 11 | First config index that is written to both banks |
| ins_valid | input | NTHR | Per-thread instruction valid |
| ins_word | input | NTHR*32 | Per-thread instruction word, thread t at [t*32 +: 32] |
| ins_ready | output | NTHR | Per-thread instruction accept |
| gpr_rd_thr | output | TW | Thread whose registers are read |
| gpr_rd_grp | output | 4 | Aligned four-register group being read |
| gpr_rd_data | input | 128 | Group contents, register 4g+k at [k*32 +: 32] |
| gpr_wr_en | output | 1 | Register write strobe |
| gpr_wr_thr | output | TW | Thread of the register write |
| gpr_wr_idx | output | 6 | Register index of the write |
| gpr_wr_data | output | 32 | Register write data |
| tcfg_flat | output | NTHR*TCFG_N*16 | All thread-setting entries |
| rd_pending | output | NTHR | Per-thread read-result-outstanding flag |
| pipe_busy | output | 1 | Shared pipe holds an operation |

## Verification
The bench builds the unit with three threads, 32 shared words, 8 entries per thread, the clearing index at 5, the bank-select entry at 1 and the broadcast base at 24. This configuration is small enough that every word of both banks is written and then read back after each group of stimulus, and every byte lane is driven with several mask patterns. The clear, the broadcast range and the per-thread bank choice all fall inside the word range that is swept. With three competing threads, the round-robin order can be told apart from a fixed priority, and the read timing is checked cycle by cycle.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
  localparam logic [7:0] OP_WR  = 8'hB0;
  localparam logic [7:0] OP_RD  = 8'hB1;
  localparam logic [7:0] OP_TC  = 8'hB2;
  localparam logic [7:0] OP_BY0 = 8'hB3;
  localparam logic [7:0] OP_BY3 = 8'hB6;

  typedef enum logic [1:0] {K_WR32, K_WR128, K_RD, K_BYTE} kind_e;

  typedef struct packed {
    logic         vld;
    kind_e        kind;
    logic         bank;
    logic [10:0]  cidx;
    logic [5:0]   gidx;
    logic [1:0]   lane;
    logic [7:0]   mask;
    logic [7:0]   bdat;
    logic [127:0] grp;
  } pipe_t;

  function automatic logic is_shared(input logic [7:0] op);
    return (op == OP_WR) || (op == OP_RD) || ((op >= OP_BY0) && (op <= OP_BY3));
  endfunction
endpackage

// File: rtl/cfgu_rr_arb.sv
module cfgu_rr_arb #(
  parameter int N = 3,
  localparam int TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [TW-1:0] gsel,
  output logic          gv
);
  logic [TW-1:0] last;

  // search starts just after the thread served most recently
  always_comb begin
    gnt  = '0;
    gsel = '0;
    gv   = 1'b0;
    for (int off = 1; off <= N; off++) begin
      if (!gv && req[(int'(last) + off) % N]) begin
        gv   = 1'b1;
        gsel = TW'((int'(last) + off) % N);
        gnt[(int'(last) + off) % N] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     last <= TW'(N - 1);
    else if (gv) last <= gsel;
  end
endmodule

// File: rtl/cfgu_tcfg_store.sv
module cfgu_tcfg_store #(
  parameter int NTHR     = 3,
  parameter int TCFG_N   = 16,
  parameter int BSEL_IDX = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NTHR-1:0]            wr,
  input  logic [NTHR*32-1:0]         words,
  output logic [NTHR*TCFG_N*16-1:0]  flat,
  output logic [NTHR-1:0]            bsel
);
  localparam int EW = (TCFG_N > 1) ? $clog2(TCFG_N) : 1;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [15:0] ent [TCFG_N];
    logic [7:0]  idx;
    assign idx = words[t*32+16 +: 8];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int e = 0; e < TCFG_N; e++) ent[e] <= '0;
      end else if (wr[t] && ({1'b0, idx} < 9'(TCFG_N))) begin
        ent[idx[EW-1:0]] <= words[t*32 +: 16];
      end
    end

    for (genvar e = 0; e < TCFG_N; e++) begin : g_ent
      assign flat[(t*TCFG_N+e)*16 +: 16] = ent[e];
    end
    assign bsel[t] = ent[BSEL_IDX][0];
  end
endmodule

// File: rtl/cfgu_cfg_exec.sv
module cfgu_cfg_exec
  import cfgu_pkg::*;
#(
  parameter int CFG_N   = 64,
  parameter int RST_IDX = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [10:0] glob_base,
  input  pipe_t       op_i,
  output logic        rd_v,
  output logic [31:0] rd_data
);
  localparam int CAW = $clog2(CFG_N);

  logic [31:0] mem [2][CFG_N];
  logic [3:0]  wen;
  logic [10:0] wi [4];
  logic [31:0] wd [4];
  logic        clr;
  logic [31:0] old_w, lmask, merged;

  always_comb begin
    old_w  = ({1'b0, op_i.cidx} < 12'(CFG_N)) ? mem[op_i.bank][op_i.cidx[CAW-1:0]] : '0;
    lmask  = {24'b0, op_i.mask} << {op_i.lane, 3'b000};
    merged = (old_w & ~lmask) | (({24'b0, op_i.bdat} << {op_i.lane, 3'b000}) & lmask);
    wen = '0;
    clr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wi[k] = '0;
      wd[k] = '0;
    end
    case (op_i.kind)
      K_WR32: begin
        wen[0] = 1'b1;
        wi[0]  = op_i.cidx;
        wd[0]  = op_i.grp[{op_i.gidx[1:0], 5'b00000} +: 32];
      end
      K_WR128: begin
        for (int k = 0; k < 4; k++) begin
          wen[k] = 1'b1;
          wi[k]  = {op_i.cidx[10:2], 2'(k)};
          wd[k]  = op_i.grp[k*32 +: 32];
        end
      end
      K_BYTE: begin
        wen[0] = 1'b1;
        wi[0]  = op_i.cidx;
        wd[0]  = merged;
      end
      default: ;
    endcase
    if (!op_i.vld) wen = '0;
    for (int k = 0; k < 4; k++) begin
      if ({1'b0, wi[k]} >= 12'(CFG_N)) wen[k] = 1'b0;
      if (wen[k] && (op_i.kind != K_BYTE) && (wi[k] == 11'(RST_IDX))) clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < CFG_N; w++) mem[b][w] <= '0;
      rd_v    <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_v    <= op_i.vld && (op_i.kind == K_RD);
      rd_data <= old_w;
      if (clr) begin
        for (int w = 0; w < CFG_N; w++)
          if (11'(w) < glob_base) mem[op_i.bank][w] <= '0;
      end
      for (int k = 0; k < 4; k++) begin
        if (wen[k]) begin
          mem[op_i.bank][wi[k][CAW-1:0]] <= wd[k];
          if (wi[k] >= glob_base) mem[~op_i.bank][wi[k][CAW-1:0]] <= wd[k];
        end
      end
    end
  end
endmodule

// File: rtl/cfg_bank_unit.sv
module cfg_bank_unit
  import cfgu_pkg::*;
#(
  parameter int NTHR     = 3,
  parameter int CFG_N    = 64,
  parameter int TCFG_N   = 16,
  parameter int RST_IDX  = 2,
  parameter int BSEL_IDX = 0,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [10:0]                glob_base,
  input  logic [NTHR-1:0]            ins_valid,
  input  logic [NTHR*32-1:0]         ins_word,
  output logic [NTHR-1:0]            ins_ready,
  output logic [TW-1:0]              gpr_rd_thr,
  output logic [3:0]                 gpr_rd_grp,
  input  logic [127:0]               gpr_rd_data,
  output logic                       gpr_wr_en,
  output logic [TW-1:0]              gpr_wr_thr,
  output logic [5:0]                 gpr_wr_idx,
  output logic [31:0]                gpr_wr_data,
  output logic [NTHR*TCFG_N*16-1:0]  tcfg_flat,
  output logic [NTHR-1:0]            rd_pending,
  output logic                       pipe_busy
);
  logic [NTHR-1:0] req, tc_wr, gnt, bsel;
  logic [TW-1:0]   gsel, s1_thr, rq_thr;
  logic            gv, rd_v;
  logic [31:0]     wsel, rd_data;
  logic [7:0]      lane_d;
  logic [5:0]      rq_gidx;
  pipe_t           nxt, s1;

  for (genvar t = 0; t < NTHR; t++) begin : g_in
    logic [7:0] opc;
    assign opc          = ins_word[t*32+24 +: 8];
    assign req[t]       = !rst && ins_valid[t] && is_shared(opc);
    assign tc_wr[t]     = !rst && ins_valid[t] && (opc == OP_TC);
    // non-shared words (thread-setting or unknown) never wait
    assign ins_ready[t] = !rst && (gnt[t] || !is_shared(opc));
  end

  cfgu_rr_arb #(.N(NTHR)) u_arb (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .gsel(gsel), .gv(gv)
  );

  cfgu_tcfg_store #(.NTHR(NTHR), .TCFG_N(TCFG_N), .BSEL_IDX(BSEL_IDX)) u_tcfg (
    .clk(clk), .rst(rst), .wr(tc_wr), .words(ins_word), .flat(tcfg_flat), .bsel(bsel)
  );

  assign wsel       = ins_word[gsel*32 +: 32];
  assign gpr_rd_thr = gsel;
  assign gpr_rd_grp = wsel[21:18];
  assign lane_d     = wsel[31:24] - OP_BY0;

  always_comb begin
    nxt      = '0;
    nxt.vld  = gv;
    nxt.bank = bsel[gsel];
    nxt.grp  = gpr_rd_data;
    nxt.gidx = wsel[21:16];
    nxt.cidx = wsel[10:0];
    nxt.mask = wsel[23:16];
    nxt.bdat = wsel[15:8];
    nxt.lane = lane_d[1:0];
    case (wsel[31:24])
      OP_WR:   nxt.kind = wsel[15] ? K_WR128 : K_WR32;
      OP_RD:   nxt.kind = K_RD;
      default: begin
        nxt.kind = K_BYTE;
        nxt.cidx = {3'b000, wsel[7:0]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= '0;
      s1_thr  <= '0;
      rq_thr  <= '0;
      rq_gidx <= '0;
    end else begin
      s1      <= nxt;
      s1_thr  <= gsel;
      rq_thr  <= s1_thr;
      rq_gidx <= s1.gidx;
    end
  end

  cfgu_cfg_exec #(.CFG_N(CFG_N), .RST_IDX(RST_IDX)) u_exec (
    .clk(clk), .rst(rst), .glob_base(glob_base), .op_i(s1), .rd_v(rd_v), .rd_data(rd_data)
  );

  assign gpr_wr_en   = rd_v;
  assign gpr_wr_thr  = rq_thr;
  assign gpr_wr_idx  = rq_gidx;
  assign gpr_wr_data = rd_data;
  assign pipe_busy   = s1.vld || rd_v;

  for (genvar t = 0; t < NTHR; t++) begin : g_pend
    assign rd_pending[t] = (s1.vld && (s1.kind == K_RD) && (s1_thr == TW'(t)))
                         || (rd_v && (rq_thr == TW'(t)));
  end
endmodule

// File: rtl/cfgu_checker.sv
module cfgu_checker #(
  parameter int NTHR = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NTHR-1:0]   ins_valid,
  input logic [NTHR-1:0]   ins_ready,
  input logic [NTHR*32-1:0] ins_word,
  input logic              pipe_busy,
  input logic [NTHR-1:0]   rd_pending,
  input logic              gpr_wr_en
);
  logic [NTHR-1:0] acc_sh, acc_rd;

  for (genvar t = 0; t < NTHR; t++) begin : g_t
    logic [7:0] opc;
    logic [7:0] wcnt;
    assign opc       = ins_word[t*32+24 +: 8];
    assign acc_sh[t] = ins_valid[t] && ins_ready[t] && cfgu_pkg::is_shared(opc);
    assign acc_rd[t] = ins_valid[t] && ins_ready[t] && (opc == cfgu_pkg::OP_RD);

    always_ff @(posedge clk) begin
      if (rst) wcnt <= '0;
      else if (ins_valid[t] && cfgu_pkg::is_shared(opc) && !ins_ready[t]) wcnt <= wcnt + 8'd1;
      else wcnt <= '0;
    end

    p_tc_ready_r1: assert property (@(posedge clk) disable iff (rst)
      (ins_valid[t] && (opc == cfgu_pkg::OP_TC)) |-> ins_ready[t]);
    p_pending_r4: assert property (@(posedge clk) disable iff (rst)
      acc_rd[t] |=> rd_pending[t]);
    p_no_starve_r9: assert property (@(posedge clk) disable iff (rst)
      wcnt < 8'(NTHR));
  end

  p_one_issue_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(acc_sh));
  p_busy_r9: assert property (@(posedge clk) disable iff (rst) (|acc_sh) |=> pipe_busy);
  p_rd_latency_r4: assert property (@(posedge clk) disable iff (rst)
    gpr_wr_en |-> $past(|acc_rd, 2));
endmodule

bind cfg_bank_unit cfgu_checker #(.NTHR(NTHR)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .ins_word(ins_word), .pipe_busy(pipe_busy), .rd_pending(rd_pending),
  .gpr_wr_en(gpr_wr_en)
);

// File: tb/cfg_bank_unit_test.sv
`timescale 1ns/1ps
module cfg_bank_unit_test;
  localparam int NT = 3, CN = 32, TN = 8, RSTI = 5, BSI = 1, GB = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0]    ins_valid = '0, ins_ready;
  logic [95:0]   ins_word = '0;
  logic [1:0]    gpr_rd_thr, gpr_wr_thr;
  logic [3:0]    gpr_rd_grp;
  logic [127:0]  gpr_rd_data;
  logic          gpr_wr_en, pipe_busy;
  logic [5:0]    gpr_wr_idx;
  logic [31:0]   gpr_wr_data;
  logic [NT*TN*16-1:0] tcfg_flat;
  logic [2:0]    rd_pending;

  logic [31:0] opnd [3][64];
  logic [31:0] dst  [3][64];
  logic [31:0] mcfg [2][CN];
  logic [15:0] mtc  [3][TN];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfg_bank_unit #(.NTHR(NT), .CFG_N(CN), .TCFG_N(TN), .RST_IDX(RSTI), .BSEL_IDX(BSI)) uut (
    .clk(clk), .rst(rst), .glob_base(11'(GB)), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_ready(ins_ready), .gpr_rd_thr(gpr_rd_thr), .gpr_rd_grp(gpr_rd_grp),
    .gpr_rd_data(gpr_rd_data), .gpr_wr_en(gpr_wr_en), .gpr_wr_thr(gpr_wr_thr),
    .gpr_wr_idx(gpr_wr_idx), .gpr_wr_data(gpr_wr_data), .tcfg_flat(tcfg_flat),
    .rd_pending(rd_pending), .pipe_busy(pipe_busy)
  );

  always_comb
    for (int k = 0; k < 4; k++)
      gpr_rd_data[k*32 +: 32] = (gpr_rd_thr < 2'd3) ? opnd[gpr_rd_thr][{gpr_rd_grp, 2'(k)}] : '0;

  always @(posedge clk)
    if (gpr_wr_en && gpr_wr_thr < 2'd3) dst[gpr_wr_thr][gpr_wr_idx] <= gpr_wr_data;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bank_of(input int t);
    return int'(mtc[t][BSI][0]);
  endfunction

  task automatic m_wr(input int b, input int idx, input logic [31:0] v);
    if (idx < CN) begin
      mcfg[b][idx] = v;
      if (idx >= GB) mcfg[1-b][idx] = v;
    end
  endtask

  task automatic m_clear(input int b);
    for (int w = 0; w < GB && w < CN; w++) mcfg[b][w] = '0;
  endtask

  task automatic issue1(input int t, input logic [31:0] w);
    @(negedge clk);
    ins_valid[t] = 1'b1;
    ins_word[t*32 +: 32] = w;
    #1;
    while (!ins_ready[t]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    ins_valid[t] = 1'b0;
  endtask

  task automatic setc(input int t, input int idx, input logic [15:0] v);
    if (idx < TN) mtc[t][idx] = v;
    issue1(t, {8'hB2, 8'(idx), v});
  endtask

  task automatic wr32(input int t, input int g, input int c, input logic [31:0] v);
    opnd[t][g] = v;
    if (c == RSTI) m_clear(bank_of(t));
    m_wr(bank_of(t), c, v);
    issue1(t, {8'hB0, 2'b00, 6'(g), 1'b0, 4'b0000, 11'(c)});
  endtask

  task automatic wr128(input int t, input int g, input int c);
    int base, gb4;
    base = c & ~3;
    gb4  = g & ~3;
    if (RSTI >= base && RSTI <= base + 3) m_clear(bank_of(t));
    for (int k = 0; k < 4; k++) m_wr(bank_of(t), base + k, opnd[t][gb4 + k]);
    issue1(t, {8'hB0, 2'b00, 6'(g), 1'b1, 4'b0000, 11'(c)});
  endtask

  task automatic rmw(input int t, input int lane, input logic [7:0] m, input logic [7:0] d, input int c);
    logic [31:0] o, lm, nw;
    o  = mcfg[bank_of(t)][c];
    lm = 32'(m) << (lane*8);
    nw = (o & ~lm) | ((32'(d) << (lane*8)) & lm);
    m_wr(bank_of(t), c, nw);
    issue1(t, {8'(8'hB3 + lane), m, d, 8'(c)});
  endtask

  task automatic rdchk(input int t, input int g, input int c, input string req);
    logic [31:0] e;
    e = mcfg[bank_of(t)][c];
    issue1(t, {8'hB1, 2'b00, 6'(g), 5'b00000, 11'(c)});
    repeat (2) @(negedge clk);
    chk(dst[t][g] == e, req, dst[t][g], e);
  endtask

  function automatic string tag_of(input int c);
    if (c >= GB) return "R6 broadcast";
    if (c < RSTI) return "R8 clear";
    return "R2 word";
  endfunction

  task automatic check_bank(input int b);
    setc(2, BSI, 16'(b));
    for (int i = 0; i < CN; i++) rdchk(2, (i*7 + b + 1) % 64, i, tag_of(i));
  endtask

  task automatic round3(input logic [2:0] who, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input int e0, input int e1, input int e2);
    int ord [3];
    int n, cyc;
    logic [2:0] acc;
    n = 0;
    cyc = 0;
    @(negedge clk);
    ins_word = {w2, w1, w0};
    ins_valid = who;
    while (ins_valid != 3'b000) begin
      #1;
      acc = ins_valid & ins_ready;
      chk($countones(acc) == 1, "R9 one per cycle", 32'(acc), 32'd1);
      for (int t = 0; t < 3; t++) if (acc[t] && n < 3) begin ord[n] = t; n++; end
      @(negedge clk);
      ins_valid = ins_valid & ~acc;
      cyc++;
    end
    chk(cyc == $countones(who), "R9 back-to-back", 32'(cyc), 32'($countones(who)));
    if ($countones(who) == 3) begin
      chk(ord[0] == e0, "R9 order0", 32'(ord[0]), 32'(e0));
      chk(ord[1] == e1, "R9 order1", 32'(ord[1]), 32'(e1));
      chk(ord[2] == e2, "R9 order2", 32'(ord[2]), 32'(e2));
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 3; t++) begin
      for (int g = 0; g < 64; g++) begin
        opnd[t][g] = 32'h1000_0000 * (t + 1) + 32'(g * 32'h0001_0203);
        dst[t][g]  = '0;
      end
      for (int e = 0; e < TN; e++) mtc[t][e] = '0;
    end
    for (int b = 0; b < 2; b++) for (int w = 0; w < CN; w++) mcfg[b][w] = '0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(tcfg_flat == '0, "R10 tcfg", 32'(tcfg_flat[31:0]), 0);
    chk(!pipe_busy && rd_pending == 3'b000 && !gpr_wr_en, "R10 idle",
        {29'd0, pipe_busy, |rd_pending, gpr_wr_en}, 0);
    for (int i = 0; i < CN; i += 4) rdchk(0, i, i, "R10 zero word");

    // R1 three simultaneous thread-setting writes
    @(negedge clk);
    ins_word = {8'hB2, 8'd7, 16'hBEEF, 8'hB2, 8'd1, 16'h0001, 8'hB2, 8'd3, 16'h1111};
    ins_valid = 3'b111;
    #1;
    chk(ins_ready == 3'b111, "R1 all accepted", 32'(ins_ready), 32'h7);
    @(negedge clk);
    ins_valid = '0;
    mtc[0][3] = 16'h1111;
    mtc[1][1] = 16'h0001;
    mtc[2][7] = 16'hBEEF;
    issue1(0, {8'hB2, 8'd9, 16'hDEAD}); // index beyond table: no effect
    for (int t = 0; t < 3; t++)
      for (int e = 0; e < TN; e++)
        chk(tcfg_flat[(t*TN+e)*16 +: 16] == mtc[t][e], "R1 entry",
            32'(tcfg_flat[(t*TN+e)*16 +: 16]), 32'(mtc[t][e]));

    // R2/R5/R6/R8 full sweeps: thread 0 on bank 0, thread 1 on bank 1
    for (int c = 0; c < CN; c++) wr32(0, (c*5 + 1) % 64, c, 32'hA000_0000 | 32'(c * 32'h0101));
    for (int c = 0; c < CN; c++) wr32(1, (c*3 + 2) % 64, c, 32'hB000_0000 | 32'(c * 32'h0307));
    check_bank(0);
    check_bank(1);
    // R8: refill bank 1 low words, then clear only bank 0; byte update on clearing index
    for (int c = 0; c < RSTI; c++) wr32(1, 40 + c, c, 32'hC0C0_0000 | 32'(c));
    wr32(0, 50, RSTI, 32'h5555_AAAA);
    rmw(1, 2, 8'hF0, 8'h3C, RSTI);
    check_bank(0);
    check_bank(1);

    // R3 wide writes, unaligned indices, including clear and broadcast ranges
    wr128(0, 7, 9);
    wr128(0, 33, 26);
    wr128(1, 62, 6);
    wr128(1, 18, 17);
    check_bank(0);
    check_bank(1);

    // R7 byte lanes with several masks
    for (int lane = 0; lane < 4; lane++) begin
      rmw(1, lane, 8'hFF, 8'h5A, 10 + lane);
      rmw(1, lane, 8'h0F, 8'hC3, 10 + lane);
      rmw(1, lane, 8'h00, 8'hFF, 14 + lane);
      rmw(0, lane, 8'hA5, 8'h3C, 25 + lane);
      rmw(0, lane, 8'h81, 8'h7E, 18);
    end
    check_bank(0);
    check_bank(1);

    // R4 read timing
    @(negedge clk);
    ins_word[2*32 +: 32] = {8'hB1, 2'b00, 6'd44, 5'b00000, 11'd11};
    ins_valid[2] = 1'b1;
    #1;
    chk(ins_ready[2], "R4 accept", 32'(ins_ready[2]), 1);
    @(negedge clk);
    ins_valid[2] = 1'b0;
    chk(rd_pending == 3'b100 && !gpr_wr_en, "R4 pending first",
        {28'd0, rd_pending, gpr_wr_en}, 32'b1000);
    @(negedge clk);
    chk(rd_pending == 3'b100 && gpr_wr_en && gpr_wr_thr == 2'd2 && gpr_wr_idx == 6'd44,
        "R4 write cycle", {22'd0, rd_pending, gpr_wr_en, gpr_wr_idx}, {22'd0, 3'b100, 1'b1, 6'd44});
    chk(gpr_wr_data == mcfg[bank_of(2)][11], "R4 data", gpr_wr_data, mcfg[bank_of(2)][11]);
    @(negedge clk);
    chk(rd_pending == 3'b000 && !gpr_wr_en, "R4 released", {28'd0, rd_pending, gpr_wr_en}, 0);
    rdchk(2, 45, 40 % CN, "R4 out of range low half"); // index 8 inside range
    issue1(2, {8'hB1, 2'b00, 6'd46, 5'b00000, 11'd700});
    repeat (2) @(negedge clk);
    chk(dst[2][46] == '0, "R4 out-of-range reads zero", dst[2][46], 0);

    // R9 round-robin: last served is thread 2
    opnd[0][20] = 32'h0101_0101; opnd[1][21] = 32'h0202_0202; opnd[2][22] = 32'h0303_0303;
    m_wr(bank_of(0), 19, opnd[0][20]);
    m_wr(bank_of(1), 20, opnd[1][21]);
    m_wr(bank_of(2), 21, opnd[2][22]);
    round3(3'b111, {8'hB0, 2'b00, 6'd20, 5'b0, 11'd19}, {8'hB0, 2'b00, 6'd21, 5'b0, 11'd20},
           {8'hB0, 2'b00, 6'd22, 5'b0, 11'd21}, 0, 1, 2);
    opnd[1][23] = 32'h0404_0404;
    m_wr(bank_of(1), 22, opnd[1][23]);
    round3(3'b010, 32'd0, {8'hB0, 2'b00, 6'd23, 5'b0, 11'd22}, 32'd0, 0, 0, 0);
    opnd[0][24] = 32'h0505_0505; opnd[1][25] = 32'h0606_0606; opnd[2][26] = 32'h0707_0707;
    m_wr(bank_of(0), 1, opnd[0][24]);
    m_wr(bank_of(1), 2, opnd[1][25]);
    m_wr(bank_of(2), 3, opnd[2][26]);
    round3(3'b111, {8'hB0, 2'b00, 6'd24, 5'b0, 11'd1}, {8'hB0, 2'b00, 6'd25, 5'b0, 11'd2},
           {8'hB0, 2'b00, 6'd26, 5'b0, 11'd3}, 2, 0, 1);
    check_bank(0);
    check_bank(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule